// File: doc/BRIEF.md
# Master-Mode ADC Result Frame Transmitter

This block sends each new conversion result out over a three-wire serial link in which it is the clock master. When the converter signals that a conversion has finished, the block captures the 12-bit result together with the 3-bit channel address held in the control register. It then produces a 16-bit frame on its own serial clock. The frame is qualified by an active-low frame sync, and the data line carries an output-enable that drives an external tri-state buffer.

The serial clock comes from the system clock through a divider. `DIV_HALF` system cycles make one half period, so the clock has a 50% duty cycle. Between frames the serial clock rests high. Each bit is launched on a rising serial-clock edge and is meant to be sampled by the receiver on the next falling edge. The sixteenth rising edge ends the frame: the frame sync returns high and the data driver is released. A mode input selects master operation. While that input is low the block drives nothing and ignores conversion strobes.

Top module: `adc_frame_tx`

## Requirements
- R1: When `eoc` is high at a clock edge, the block is idle and `master_en` is high, the frame starts at that edge. From then on `frame_n` is 0, `dat_oe` is 1, `ser_clk` is 1 and `ser_dat` carries frame bit 0.
- R2: A frame carries 16 bits. Bit 0 is a constant 0. Bits 1 to 3 are `chan_addr[2]`, `chan_addr[1]`, `chan_addr[0]`. Bits 4 to 15 are `result[11]` down to `result[0]`. Bit k (k ≥ 1) is driven from the k-th rising edge of `ser_clk` until the next rising edge. Bit 0 is driven from the frame start until the first rising edge.
- R3: Inside a frame, `ser_clk` changes level every `DIV_HALF` system cycles. The first change is a fall, `DIV_HALF` cycles after the frame start. Outside a frame `ser_clk` is 1.
- R4: `frame_n` stays low for exactly 32·`DIV_HALF` system cycles. It returns high on the same clock edge as the sixteenth rising edge of `ser_clk`.
- R5: `dat_oe` is 1 exactly while `frame_n` is 0. `ser_dat` is 0 whenever `dat_oe` is 0.
- R6: An `eoc` pulse that arrives during a frame is ignored. The frame's content and timing stay unchanged, and no second frame follows from that pulse.
- R7: While `master_en` is 0, the outputs are inactive at once: `ser_clk`=1, `frame_n`=1, `dat_oe`=0, `ser_dat`=0. Any frame in progress is abandoned, and `eoc` is ignored.
- R8: An `eoc` seen on the edge that ends a frame is ignored. An `eoc` seen on the following edge starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Selects master operation; low forces all outputs inactive |
| eoc | input | 1 | End-of-conversion strobe |
| result | input | RES_W | Conversion result to send |
| chan_addr | input | ADDR_W | Channel address from the control register |
| ser_clk | output | 1 | Serial clock, high at rest |
| frame_n | output | 1 | Active-low frame sync |
| ser_dat | output | 1 | Serial data, to the tri-state buffer |
| dat_oe | output | 1 | Enable for the data tri-state buffer |

## Verification
The frame outputs change on the same edge that samples `eoc`. After that, each level change of `ser_clk` follows its predecessor by `DIV_HALF` edges. A new data bit appears on every second change, and the frame ends at 32·`DIV_HALF` edges. The bench keeps a behavioural count of edges since the frame start and derives all four expected outputs from that count. It compares them with the outputs at every falling system-clock edge, halfway between updates. The effect of `master_en` is combinational, so it is checked in the same half cycle in which the input changes.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

    localparam int ADDR_W_DEF   = 3;
    localparam int RES_W_DEF    = 12;
    localparam int DIV_HALF_DEF = 2;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // A transition count that is even and non-zero is a rising edge.
    function automatic logic is_rise(input logic [7:0] cnt);
        return (cnt != 8'd0) && !cnt[0];
    endfunction

endpackage

// File: rtl/adc_frame_tick.sv
module adc_frame_tick #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int PH_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV_HALF - 1);

    logic [PH_W-1:0] phase;

    assign tick = run && (phase == PH_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               shift,
    input  logic [FRAME_W-1:0] din,
    output logic               msb
);
    logic [FRAME_W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= din;
        end else if (shift) begin
            sreg <= {sreg[FRAME_W-2:0], 1'b0};
        end
    end

    assign msb = sreg[FRAME_W-1];
endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx
    import adc_frame_pkg::*;
#(
    parameter int ADDR_W   = ADDR_W_DEF,
    parameter int RES_W    = RES_W_DEF,
    parameter int DIV_HALF = DIV_HALF_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              eoc,
    input  logic [RES_W-1:0]  result,
    input  logic [ADDR_W-1:0] chan_addr,
    output logic              ser_clk,
    output logic              frame_n,
    output logic              ser_dat,
    output logic              dat_oe
);
    localparam int FRAME_W = 1 + ADDR_W + RES_W;
    localparam int N_EDGES = 2 * FRAME_W;
    localparam int EDGE_W  = $clog2(N_EDGES + 1);
    localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(N_EDGES);

    tx_state_e         state;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_nxt;
    logic              sclk_q;
    logic              tick;
    logic              start;
    logic              do_shift;
    logic              msb;
    logic              busy;

    assign busy     = (state == TX_SEND);
    assign start    = master_en && !busy && eoc;
    assign edge_nxt = edge_cnt + 1'b1;
    assign do_shift = tick && is_rise(8'(edge_nxt)) && (edge_nxt != EDGE_LAST);

    adc_frame_tick #(.DIV_HALF(DIV_HALF)) u_tick (
        .clk (clk),
        .rst (rst),
        .run (busy && master_en),
        .tick(tick)
    );

    adc_frame_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .shift(do_shift),
        .din  ({1'b0, chan_addr, result}),
        .msb  (msb)
    );

    always_ff @(posedge clk) begin
        if (rst || !master_en) begin
            state    <= TX_IDLE;
            edge_cnt <= '0;
            sclk_q   <= 1'b1;
        end else if (start) begin
            state    <= TX_SEND;
            edge_cnt <= '0;
            sclk_q   <= 1'b1;
        end else if (tick) begin
            edge_cnt <= edge_nxt;
            sclk_q   <= ~sclk_q;
            if (edge_nxt == EDGE_LAST) begin
                state <= TX_IDLE;
            end
        end
    end

    assign dat_oe  = busy && master_en;
    assign frame_n = ~dat_oe;
    assign ser_clk = sclk_q | ~master_en;
    assign ser_dat = dat_oe & msb;
endmodule

// File: rtl/adc_frame_tx_chk.sv
module adc_frame_tx_chk (
    input logic clk,
    input logic rst,
    input logic master_en,
    input logic eoc,
    input logic ser_clk,
    input logic frame_n,
    input logic ser_dat,
    input logic dat_oe
);
    logic       sclk_d;
    logic [4:0] rise_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b1;
            rise_cnt <= '0;
        end else begin
            sclk_d <= ser_clk;
            if (frame_n) begin
                rise_cnt <= '0;
            end else if (ser_clk && !sclk_d) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    a_r1_frame_starts: assert property (@(posedge clk) disable iff (rst)
        (master_en && eoc && frame_n) |=> (!frame_n || !master_en));

    a_r3_idle_clock_high: assert property (@(posedge clk) disable iff (rst)
        frame_n |-> ser_clk);

    a_r5_data_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !dat_oe |-> !ser_dat);

    a_r5_oe_matches_frame: assert property (@(posedge clk) disable iff (rst)
        dat_oe == !frame_n);

    a_r7_disabled_inactive: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> (frame_n && !dat_oe && ser_clk));

    a_r4_end_on_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame_n) && master_en && $past(master_en)) |-> (!sclk_d && ser_clk));

    a_r4_sixteenth_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(frame_n) && master_en && $past(master_en)) |-> (rise_cnt == 5'd15));
endmodule

bind adc_frame_tx adc_frame_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .master_en(master_en),
    .eoc      (eoc),
    .ser_clk  (ser_clk),
    .frame_n  (frame_n),
    .ser_dat  (ser_dat),
    .dat_oe   (dat_oe)
);

// File: tb/adc_frame_tx_tb.sv
module adc_frame_tx_tb;
    localparam int H     = 2;
    localparam int FLEN  = 32 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_en = 1'b1;
    logic        eoc = 1'b0;
    logic [11:0] result = '0;
    logic [2:0]  chan_addr = '0;
    logic        ser_clk, frame_n, ser_dat, dat_oe;

    int    n_checks = 0;
    int    n_fail   = 0;
    string tag      = "R5";
    bit    done     = 1'b0;

    always #5 clk = ~clk;

    adc_frame_tx #(.ADDR_W(3), .RES_W(12), .DIV_HALF(H)) u_dut (
        .clk(clk), .rst(rst), .master_en(master_en), .eoc(eoc),
        .result(result), .chan_addr(chan_addr),
        .ser_clk(ser_clk), .frame_n(frame_n), .ser_dat(ser_dat), .dat_oe(dat_oe)
    );

    // Behavioural reference: cycles since frame start and the captured frame.
    bit          m_act = 1'b0;
    int          m_t   = 0;
    logic [15:0] m_frm = '0;

    always @(posedge clk) begin
        if (rst || !master_en) begin
            m_act = 1'b0;
        end else if (m_act) begin
            m_t = m_t + 1;
            if (m_t == FLEN) m_act = 1'b0;
        end else if (eoc) begin
            m_act = 1'b1;
            m_t   = 0;
            m_frm = {1'b0, chan_addr, result};
        end
    end

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at %0t: got %b expected %b", req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic e_clk, e_fn, e_dat, e_oe;
            if (!master_en || !m_act) begin
                e_clk = 1'b1; e_fn = 1'b1; e_dat = 1'b0; e_oe = 1'b0;
            end else begin
                e_clk = ((m_t / H) % 2) == 0;
                e_fn  = 1'b0;
                e_oe  = 1'b1;
                e_dat = m_frm[15 - (m_t / H) / 2];
            end
            check(master_en ? "R3" : "R7", {tag, " ser_clk"}, ser_clk, e_clk);
            check(master_en ? "R4" : "R7", {tag, " frame_n"}, frame_n, e_fn);
            check(master_en ? "R2" : "R7", {tag, " ser_dat"}, ser_dat, e_dat);
            check(master_en ? "R5" : "R7", {tag, " dat_oe"},  dat_oe,  e_oe);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_eoc(input logic [2:0] a, input logic [11:0] r);
        chan_addr = a;
        result    = r;
        eoc       = 1'b1;
        @(negedge clk);
        eoc       = 1'b0;
    endtask

    initial begin
        cycles(4);
        rst = 1'b0;
        cycles(1);
        tag = "R5";
        check("R5", "reset frame_n", frame_n, 1'b1);
        check("R3", "reset ser_clk", ser_clk, 1'b1);

        // R1 / R2: ordinary frame, start seen right after the strobe edge
        tag = "R1";
        pulse_eoc(3'b101, 12'hA5C);
        check("R1", "start frame_n", frame_n, 1'b0);
        check("R1", "start dat_oe", dat_oe, 1'b1);
        tag = "R2";
        cycles(FLEN + 2);

        tag = "R2";
        pulse_eoc(3'b111, 12'hFFF);
        cycles(FLEN + 2);
        pulse_eoc(3'b000, 12'h000);
        cycles(FLEN + 2);
        pulse_eoc(3'b010, 12'h3C6);
        cycles(FLEN + 2);

        // R6: strobes inside a frame with different data
        tag = "R6";
        pulse_eoc(3'b001, 12'h801);
        cycles(7);
        pulse_eoc(3'b110, 12'h7FE);
        cycles(20);
        pulse_eoc(3'b011, 12'h555);
        cycles(FLEN);
        check("R6", "no second frame", frame_n, 1'b1);

        // R8: strobe held high gives back-to-back frames
        tag = "R8";
        chan_addr = 3'b100;
        result    = 12'h9A3;
        eoc       = 1'b1;
        cycles(3 * FLEN + 10);
        eoc       = 1'b0;
        cycles(FLEN + 2);

        // R7: drop mode mid frame, strobe while disabled
        tag = "R7";
        pulse_eoc(3'b011, 12'hC3A);
        cycles(13);
        master_en = 1'b0;
        cycles(2);
        pulse_eoc(3'b111, 12'h123);
        cycles(5);
        check("R7", "disabled frame_n", frame_n, 1'b1);
        master_en = 1'b1;
        cycles(3);
        check("R7", "no late frame", frame_n, 1'b1);
        tag = "R2";
        pulse_eoc(3'b110, 12'h0F0);
        cycles(FLEN + 4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule